// File: doc/BRIEF.md
# Converter Register Port with Two-Wire Serial Target

This block is the serial-bus face of a data-converter register file. It watches the open-drain SCL and SDA lines of a standard two-wire (I2C) bus with a much faster system clock. It recognises START, repeated START and STOP conditions, and answers a 7-bit target address. That address is formed from a fixed four-bit prefix and the states of two three-level strap pins. The block never drives SCL and never stretches the clock. On SDA it only pulls the line low or releases it.

A read transaction returns three bytes in this order: the 16-bit conversion result, upper byte first, then the current configuration byte. Every further byte reads as FFh. The result is captured once, when the address is acknowledged, so its two halves always belong together. A write transaction delivers one configuration byte as a single-cycle strobe. The block also serves the general-call address, with a command to re-latch the straps and a command to request a register reset. It does not acknowledge the high-speed master code; it only flags that code until the next STOP. A one-cycle pulse tells the conversion controller that the configuration byte has been read out, so that the controller can update its fresh-data status.

Top module: `i2c_cfg_target`

## Requirements
- R1: Strap encoding per pin is 00 = tied low, 01 = tied high, 1x = floating. The latched pin pair (A, B) selects the address 1001 followed by three low bits: L/L 000, L/F 001, L/H 010, F/L 011, H/L 100, H/F 101, H/H 110, F/H 111. F/F gives no address. Only an address byte whose upper seven bits match the latched address is acknowledged.
- R2: The straps are sampled during reset and afterwards only by the general-call commands of R3. A strap change at any other time leaves the answered address unchanged.
- R3: The address byte 00h (general call, write) is always acknowledged. A following byte of 04h is acknowledged and re-latches the straps. A following byte of 06h is acknowledged, re-latches the straps and pulses `rst_req_o` for one cycle. Any other following byte is not acknowledged and has no effect.
- R4: An address byte of the form 00001xxx is not acknowledged and sets `hs_mode_o`. The flag survives repeated STARTs and clears after the next STOP. It is low after reset.
- R5: A read sends, MSB first, result[15:8], result[7:0], the configuration byte and then FFh for every further byte. The result is captured when the read address is acknowledged.
- R6: A master not-acknowledge ends the read. SDA stays released for the rest of the transaction.
- R7: `cfg_rd_o` pulses for one cycle when the eighth bit of the configuration byte has been clocked out. A read that ends earlier produces no pulse.
- R8: On a write, the first data byte is acknowledged and appears on `cfg_wdata_o` with a one-cycle `cfg_wr_o`. Later bytes are neither acknowledged nor strobed.
- R9: `sda_pd_o` changes only after a synchronised SCL falling edge, or is released at START or STOP. It is held while SCL stays high, and it is low after reset.
- R10: A START or repeated START at any point abandons the current byte and restarts address reception. A STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_a_i | input | 2 | First strap pin level (00 low, 01 high, 1x floating) |
| strap_b_i | input | 2 | Second strap pin level (00 low, 01 high, 1x floating) |
| result_i | input | 16 | Current conversion result |
| cfg_i | input | 8 | Current configuration byte to return on reads |
| sda_pd_o | output | 1 | Pull SDA low when high |
| cfg_wr_o | output | 1 | One-cycle configuration write strobe |
| cfg_wdata_o | output | 8 | Configuration byte, valid with `cfg_wr_o` |
| cfg_rd_o | output | 1 | One-cycle pulse after the configuration byte is read out |
| rst_req_o | output | 1 | One-cycle register reset request from general call 06h |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |

## Verification
The bench changes the result in the middle of a read. A design that re-sampled it per byte would return a torn 16-bit value. The bench moves the straps without a general call, and also sends a general call with an unknown command, where an over-eager design would answer the new address. It sends a second write byte, which a careless design would acknowledge or strobe a second time. It ends reads early, where a design that counted wrongly would raise the configuration-read pulse, or keep driving SDA after the master's not-acknowledge. It also cuts a write byte short with a repeated START. It walks every strap combination, including the invalid floating pair, and sends the master code to check that it gets no acknowledge and that its flag lasts until STOP and no longer.

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001,
  parameter logic [7:0] GC_LATCH    = 8'h04,
  parameter logic [7:0] GC_RESET    = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  strap_a_i,
  input  logic [1:0]  strap_b_i,
  input  logic [15:0] result_i,
  input  logic [7:0]  cfg_i,
  output logic        sda_pd_o,
  output logic        cfg_wr_o,
  output logic [7:0]  cfg_wdata_o,
  output logic        cfg_rd_o,
  output logic        rst_req_o,
  output logic        hs_mode_o
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WDATA, ST_GCALL, ST_RDATA, ST_SKIP} st_t;

  // returns {valid, low three address bits}
  function automatic logic [3:0] strap_decode(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] la, lb;
    la = a[1] ? 2'd2 : {1'b0, a[0]};
    lb = b[1] ? 2'd2 : {1'b0, b[0]};
    case ({la, lb})
      4'b0000: strap_decode = 4'b1000;
      4'b0010: strap_decode = 4'b1001;
      4'b0001: strap_decode = 4'b1010;
      4'b1000: strap_decode = 4'b1011;
      4'b0100: strap_decode = 4'b1100;
      4'b0110: strap_decode = 4'b1101;
      4'b1001: strap_decode = 4'b1111;
      4'b0101: strap_decode = 4'b1110;
      default: strap_decode = 4'b0000;
    endcase
  endfunction

  st_t         state;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [3:0]  bitcnt;
  logic [7:0]  sh, tx, rd_byte;
  logic [1:0]  rd_idx;
  logic [15:0] res_q;
  logic [3:0]  addr_q;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire rx_state  = (state == ST_ADDR) || (state == ST_WDATA) || (state == ST_GCALL);
  wire addr_hit  = addr_q[3] && (sh[7:1] == {ADDR_PREFIX, addr_q[2:0]});

  assign cfg_wdata_o = sh;

  always_comb begin
    case (rd_idx)
      2'd0:    rd_byte = res_q[15:8];
      2'd1:    rd_byte = res_q[7:0];
      2'd2:    rd_byte = cfg_i;
      default: rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      state <= ST_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; rd_idx <= '0; res_q <= '0;
      sda_pd_o <= 1'b0; cfg_wr_o <= 1'b0; cfg_rd_o <= 1'b0; rst_req_o <= 1'b0; hs_mode_o <= 1'b0;
      addr_q <= strap_decode(strap_a_i, strap_b_i);
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      cfg_wr_o <= 1'b0;
      cfg_rd_o <= 1'b0;
      rst_req_o <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; bitcnt <= '0; sda_pd_o <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; bitcnt <= '0; sda_pd_o <= 1'b0; hs_mode_o <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (rx_state && bitcnt < 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (state == ST_RDATA && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (state == ST_RDATA && bitcnt == 4'd8) begin
            if (sda_s) state <= ST_SKIP;
            else bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (state == ST_RDATA) begin
              tx <= rd_byte;
              sda_pd_o <= ~rd_byte[7];
            end else begin
              sda_pd_o <= 1'b0;
            end
          end else if (state == ST_RDATA) begin
            if (bitcnt == 4'd8) begin
              sda_pd_o <= 1'b0;
              if (rd_idx == 2'd2) cfg_rd_o <= 1'b1;
              if (rd_idx != 2'd3) rd_idx <= rd_idx + 2'd1;
            end else if (bitcnt != 4'd0) begin
              tx <= {tx[6:0], 1'b1};
              sda_pd_o <= ~tx[6];
            end
          end else if (rx_state && bitcnt == 4'd8) begin
            state <= ST_SKIP;
            case (state)
              ST_ADDR: begin
                if (addr_hit) begin
                  sda_pd_o <= 1'b1; bitcnt <= 4'd9; rd_idx <= '0; res_q <= result_i;
                  state <= sh[0] ? ST_RDATA : ST_WDATA;
                end else if (sh == 8'h00) begin
                  sda_pd_o <= 1'b1; bitcnt <= 4'd9; state <= ST_GCALL;
                end else if (sh[7:3] == 5'b00001) begin
                  hs_mode_o <= 1'b1;
                end
              end
              ST_WDATA: begin
                sda_pd_o <= 1'b1; bitcnt <= 4'd9; cfg_wr_o <= 1'b1;
              end
              default: begin
                if (sh == GC_LATCH || sh == GC_RESET) begin
                  sda_pd_o <= 1'b1; bitcnt <= 4'd9;
                  addr_q <= strap_decode(strap_a_i, strap_b_i);
                  rst_req_o <= (sh == GC_RESET);
                end
              end
            endcase
          end
        end
      end
    end
  end

  // R9
  sda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> $past(scl_fall));

  // R9
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_det && !stop_det) |=> $stable(sda_pd_o));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pd_o);

  // R4
  hs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode_o);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o || cfg_rd_o || rst_req_o) |=> !(cfg_wr_o || cfg_rd_o || rst_req_o));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_wr_o, cfg_rd_o, rst_req_o}));

endmodule

// File: tb/tb_i2c_cfg_target.sv
module tb_i2c_cfg_target;
  localparam int Q = 8;
  localparam logic [1:0] LV_L = 2'b00, LV_H = 2'b01, LV_F = 2'b10;

  logic clk = 1'b0;
  logic rst_n, scl, sda_m;
  logic [1:0] strap_a, strap_b;
  logic [15:0] result;
  logic [7:0] cfg;
  logic sda_pd, cfg_wr, cfg_rd, rst_req, hs;
  logic [7:0] wdata;
  wire sda_line = sda_m & ~sda_pd;

  always #10 clk = ~clk;

  i2c_cfg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_a_i(strap_a), .strap_b_i(strap_b), .result_i(result), .cfg_i(cfg),
    .sda_pd_o(sda_pd), .cfg_wr_o(cfg_wr), .cfg_wdata_o(wdata), .cfg_rd_o(cfg_rd),
    .rst_req_o(rst_req), .hs_mode_o(hs));

  int checks = 0, failures = 0;
  int n_wr = 0, n_rd = 0, n_rst = 0;
  logic [7:0] last_wd = 8'h00;
  logic exp_on = 1'b0, exp_pd = 1'b0;
  string cur_tag = "R9";
  int model_addr;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the pull-down against the model while SCL is high (R9)
  always @(negedge clk) begin
    if (exp_on) chk(cur_tag, int'(sda_pd), int'(exp_pd));
    if (rst_n) begin
      if (cfg_wr) begin n_wr++; last_wd = wdata; end
      if (cfg_rd) n_rd++;
      if (rst_req) n_rst++;
    end
  end

  function automatic int mdl(input logic [1:0] a, input logic [1:0] b);
    case ({a, b})
      {LV_L, LV_L}: return 'h48;
      {LV_L, LV_F}: return 'h49;
      {LV_L, LV_H}: return 'h4A;
      {LV_F, LV_L}: return 'h4B;
      {LV_H, LV_L}: return 'h4C;
      {LV_H, LV_F}: return 'h4D;
      {LV_H, LV_H}: return 'h4E;
      {LV_F, LV_H}: return 'h4F;
      default:      return -1;
    endcase
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_io(input logic b, input logic e, output logic r);
    sda_m = b; wq();
    scl = 1'b1; exp_pd = e; exp_on = 1'b1; wq();
    r = sda_line; wq();
    exp_on = 1'b0; scl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, input logic exp_ack, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], 1'b0, r);
    bit_io(1'b1, exp_ack, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, ~exp[i], r);
      d[i] = r;
    end
    bit_io(~mack, 1'b0, r);
  endtask

  task automatic addr_byte(input string tag, input int a, input logic rd);
    logic ack;
    logic e;
    e = (model_addr >= 0) && (a == model_addr);
    cur_tag = tag;
    write_byte({a[6:0], rd}, e, ack);
    chk(tag, int'(ack), int'(e));
  endtask

  task automatic gcall(input string tag, input logic [7:0] cmd);
    logic ack;
    logic good;
    good = (cmd == 8'h04) || (cmd == 8'h06);
    cur_tag = tag;
    bus_start();
    write_byte(8'h00, 1'b1, ack);
    chk(tag, int'(ack), 1);
    write_byte(cmd, good, ack);
    chk(tag, int'(ack), int'(good));
    bus_stop();
    if (good) model_addr = mdl(strap_a, strap_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ack, r;
    logic [1:0] lv [3];
    lv[0] = LV_L; lv[1] = LV_H; lv[2] = LV_F;
    scl = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    strap_a = LV_L; strap_b = LV_L; result = 16'hA55A; cfg = 8'h8C;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    model_addr = mdl(strap_a, strap_b);
    repeat (5) @(negedge clk);
    chk("R9", int'(sda_pd), 0);
    chk("R4", int'(hs), 0);
    chk("R7", n_rd, 0);

    // R5 read frame with result change mid-read, R7 pulse after third byte
    bus_start();
    addr_byte("R5", 'h48, 1'b1);
    cur_tag = "R5";
    read_byte(8'hA5, 1'b1, d); chk("R5", d, 'hA5);
    result = 16'h1234;
    read_byte(8'h5A, 1'b1, d); chk("R5", d, 'h5A);
    chk("R7", n_rd, 0);
    read_byte(8'h8C, 1'b1, d); chk("R5", d, 'h8C);
    chk("R7", n_rd, 1);
    read_byte(8'hFF, 1'b0, d); chk("R5", d, 'hFF);
    bus_stop();
    chk("R7", n_rd, 1);

    // R8 single write byte
    bus_start();
    addr_byte("R8", 'h48, 1'b0);
    cur_tag = "R8";
    write_byte(8'h3C, 1'b1, ack); chk("R8", int'(ack), 1);
    chk("R8", n_wr, 1); chk("R8", last_wd, 'h3C);
    write_byte(8'h11, 1'b0, ack); chk("R8", int'(ack), 0);
    bus_stop();
    chk("R8", n_wr, 1);

    // R1 wrong address
    bus_start(); addr_byte("R1", 'h49, 1'b0); bus_stop();

    // R2 strap change without general call
    strap_a = LV_H; strap_b = LV_F;
    bus_start(); addr_byte("R2", 'h4D, 1'b0); bus_stop();
    bus_start(); addr_byte("R2", 'h48, 1'b0); bus_stop();

    // R3 general call 04h re-latches, no reset request
    gcall("R3", 8'h04);
    chk("R3", model_addr, 'h4D);
    chk("R3", n_rst, 0);
    bus_start(); addr_byte("R3", 'h48, 1'b0); bus_stop();

    // R6 early-ended read: released after NACK, no config-read pulse
    bus_start(); addr_byte("R6", 'h4D, 1'b1);
    cur_tag = "R6";
    read_byte(8'h12, 1'b0, d); chk("R5", d, 'h12);
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, 1'b0, r);
      chk("R6", int'(r), 1);
    end
    bus_stop();
    chk("R7", n_rd, 1);

    // R3 general call 06h: re-latch and reset request
    strap_a = LV_F; strap_b = LV_H;
    gcall("R3", 8'h06);
    chk("R3", n_rst, 1);
    bus_start(); addr_byte("R3", 'h4F, 1'b0); bus_stop();

    // R3 unknown general-call command has no effect
    strap_a = LV_L; strap_b = LV_H;
    gcall("R3", 8'h55);
    chk("R3", n_rst, 1);
    bus_start(); addr_byte("R3", 'h4F, 1'b0); bus_stop();
    bus_start(); addr_byte("R3", 'h4A, 1'b0); bus_stop();

    // R4 master code: no ack, flag until STOP
    bus_start();
    cur_tag = "R4";
    write_byte(8'h0B, 1'b0, ack); chk("R4", int'(ack), 0);
    chk("R4", int'(hs), 1);
    bus_start();
    addr_byte("R4", 'h4F, 1'b0);
    chk("R4", int'(hs), 1);
    bus_stop();
    wq();
    chk("R4", int'(hs), 0);

    // R10 repeated START cuts a write byte short
    bus_start();
    addr_byte("R10", 'h4F, 1'b0);
    cur_tag = "R10";
    for (int i = 0; i < 4; i++) bit_io(1'b1, 1'b0, r);
    bus_start();
    addr_byte("R10", 'h4F, 1'b1);
    read_byte(8'h12, 1'b1, d); chk("R10", d, 'h12);
    read_byte(8'h34, 1'b0, d); chk("R10", d, 'h34);
    bus_stop();
    chk("R10", n_wr, 1);
    chk("R10", int'(sda_pd), 0);

    // R1 every strap combination
    for (int ia = 0; ia < 3; ia++) begin
      for (int ib = 0; ib < 3; ib++) begin
        strap_a = lv[ia]; strap_b = lv[ib];
        gcall("R1", 8'h04);
        chk("R1", model_addr, mdl(lv[ia], lv[ib]));
        bus_start();
        addr_byte("R1", (model_addr >= 0) ? model_addr : 'h4F, 1'b0);
        bus_stop();
        bus_start(); addr_byte("R1", 'h47, 1'b0); bus_stop();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule